// File: doc/BRIEF.md
# Host Recovery Doorbell Mailbox

This block is the peripheral end of a keyboard-controller-style register pair. Here it serves as a one-way recovery doorbell. The host writes bytes into an input data register through either of two ports, a data port and a command port, and polls an 8-bit status register. The controller side has three things: a read port for the input data register, a write port for the software-owned spare status bits, and an interrupt output. Nothing is ever placed in the output direction, so the output-buffer-full flag stays clear.

A small sequencer on the controller side does the recovery handshake. Its states are:

- SQ_BOOT, entered at reset. It moves unconditionally to SQ_ARM.
- SQ_ARM sets Ready, then moves to SQ_WAIT.
- SQ_WAIT holds until input-buffer-full is seen, then moves to SQ_FETCH.
- SQ_FETCH reads the input data register, which clears the flag and captures the byte. It then moves to SQ_DECIDE.
- SQ_DECIDE returns to SQ_WAIT for any byte other than the debug code (0x44). For the debug code it moves to SQ_FIRE.
- SQ_FIRE emits a one-cycle trigger and clears Ready, then moves to SQ_HALT.
- SQ_HALT is held until reset, standing in for the dump and reboot that follow.

The host sees Ready drop and knows that recovery has started.

Top module: `kcs_doorbell`

## Requirements
- R1: The status byte seen by the host has this layout: bit 0 is output-buffer-full and always reads 0, bit 1 is input-buffer-full, bit 3 is command/data, and bit 4 is Ready. Bits 7, 6 and 5 come from spare field bits 3, 2 and 1, and bit 2 comes from spare field bit 0. Every bit is 0 during reset.
- R2: A host write on either port stores the byte in the input data register and sets input-buffer-full on the next clock edge.
- R3: Command/data becomes 1 after a write on the command port and 0 after a write on the data port.
- R4: After reset the sequencer sets Ready within three clock edges and then waits for input.
- R5: In the running state the sequencer consumes each byte, which clears input-buffer-full within three edges of the write. A byte other than 0x44 is discarded: Ready stays set and no trigger is emitted.
- R6: A consumed byte equal to 0x44, written on either port, produces exactly one single-cycle debug trigger and clears Ready. The sequencer then halts, so later bytes (0x44 included) are not consumed and cause no trigger until reset.
- R7: A controller-side read strobe clears input-buffer-full on the next edge, and the read data port shows the stored byte.
- R8: The interrupt output is high exactly while input-buffer-full is set and the interrupt enable is high.
- R9: A host write while input-buffer-full is set replaces the stored byte and leaves the flag set.
- R10: The spare write port changes only status bits 7:5 and 2. Ready and the hardware bits are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe, one byte per cycle |
| host_wr_cmd | input | 1 | 1 selects the command port, 0 the data port |
| host_wr_data | input | 8 | Byte written by the host |
| host_status | output | 8 | Status byte read by the host |
| ctl_rd_en | input | 1 | Controller read strobe for the input data register |
| ctl_rd_data | output | 8 | Stored input byte |
| ctl_spare_wr_en | input | 1 | Spare status write strobe |
| ctl_spare_wr_data | input | 4 | Spare field: bits 3:1 map to status 7:5, bit 0 to status 2 |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Controller interrupt |
| dbg_trigger | output | 1 | One-cycle debug-collection trigger |

## Verification
The assertions assume at most one host write per cycle. They also assume the controller read strobe is not raised in the same cycle as a host write. When both arrive together, the write takes priority, and the read-clears check does not cover that case. The stimulus follows these rules. Host writes are driven as single strobes or as back-to-back pairs, and the controller read strobe is used only after the sequencer has halted and the host is idle.

// File: rtl/kcs_doorbell_pkg.sv
package kcs_doorbell_pkg;

    localparam int STS_W    = 8;
    localparam int OBF_BIT  = 0;
    localparam int IBF_BIT  = 1;
    localparam int SPR0_BIT = 2;
    localparam int CD_BIT   = 3;
    localparam int RDY_BIT  = 4;
    localparam int SPR_W    = 4;

    typedef enum logic [2:0] {
        SQ_BOOT,
        SQ_ARM,
        SQ_WAIT,
        SQ_FETCH,
        SQ_DECIDE,
        SQ_FIRE,
        SQ_HALT
    } seq_state_e;

    function automatic logic [STS_W-1:0] pack_status(
        input logic             ibf,
        input logic             cd,
        input logic             ready,
        input logic [SPR_W-1:0] spare
    );
        logic [STS_W-1:0] s;
        s           = '0;
        s[OBF_BIT]  = 1'b0;
        s[IBF_BIT]  = ibf;
        s[SPR0_BIT] = spare[0];
        s[CD_BIT]   = cd;
        s[RDY_BIT]  = ready;
        s[7:5]      = spare[3:1];
        return s;
    endfunction

endpackage

// File: rtl/kcs_regs.sv
module kcs_regs
    import kcs_doorbell_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_wr_cmd,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              rd_en,
    input  logic              spare_wr_en,
    input  logic [SPR_W-1:0]  spare_wr_data,
    input  logic              ready_set,
    input  logic              ready_clr,
    output logic [DATA_W-1:0] idr,
    output logic              ibf,
    output logic [STS_W-1:0]  status
);

    logic             cd_q;
    logic             ready_q;
    logic [SPR_W-1:0] spare_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idr     <= '0;
            ibf     <= 1'b0;
            cd_q    <= 1'b0;
            ready_q <= 1'b0;
            spare_q <= '0;
        end else begin
            if (host_wr_en) begin
                idr  <= host_wr_data;
                ibf  <= 1'b1;
                cd_q <= host_wr_cmd;
            end else if (rd_en) begin
                ibf <= 1'b0;
            end
            if (ready_set) begin
                ready_q <= 1'b1;
            end else if (ready_clr) begin
                ready_q <= 1'b0;
            end
            if (spare_wr_en) begin
                spare_q <= spare_wr_data;
            end
        end
    end

    always_comb begin
        status = pack_status(ibf, cd_q, ready_q, spare_q);
    end

    // R2
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en |=> (ibf && idr == $past(host_wr_data)));

    // R7
    ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !host_wr_en) |=> !ibf);

    // R3
    cd_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en |=> (status[CD_BIT] == $past(host_wr_cmd)));

    // R10
    spare_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spare_wr_en |=> ($stable(status[7:5]) && $stable(status[SPR0_BIT])));

endmodule

// File: rtl/kcs_seq.sv
module kcs_seq
    import kcs_doorbell_pkg::*;
#(
    parameter int              DATA_W     = 8,
    parameter logic [DATA_W-1:0] DEBUG_CODE = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ibf,
    input  logic [DATA_W-1:0] idr,
    output logic              seq_rd,
    output logic              ready_set,
    output logic              ready_clr,
    output logic              trigger
);

    seq_state_e        state_q, state_d;
    logic [DATA_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (state_q == SQ_FETCH) begin
            cap_q <= idr;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_BOOT:   state_d = SQ_ARM;
            SQ_ARM:    state_d = SQ_WAIT;
            SQ_WAIT:   state_d = ibf ? SQ_FETCH : SQ_WAIT;
            SQ_FETCH:  state_d = SQ_DECIDE;
            SQ_DECIDE: state_d = (cap_q == DEBUG_CODE) ? SQ_FIRE : SQ_WAIT;
            SQ_FIRE:   state_d = SQ_HALT;
            SQ_HALT:   state_d = SQ_HALT;
            default:   state_d = SQ_BOOT;
        endcase
    end

    always_comb begin
        seq_rd    = 1'b0;
        ready_set = 1'b0;
        ready_clr = 1'b0;
        trigger   = 1'b0;
        unique case (state_q)
            SQ_ARM:   ready_set = 1'b1;
            SQ_FETCH: seq_rd    = 1'b1;
            SQ_FIRE: begin
                trigger   = 1'b1;
                ready_clr = 1'b1;
            end
            default: ;
        endcase
    end

    // R6
    fire_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_FIRE) |=> (state_q == SQ_HALT));

    // R5
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_DECIDE && cap_q != DEBUG_CODE) |=> (state_q == SQ_WAIT));

endmodule

// File: rtl/kcs_doorbell.sv
module kcs_doorbell
    import kcs_doorbell_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] DEBUG_CODE = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_wr_cmd,
    input  logic [DATA_W-1:0] host_wr_data,
    output logic [STS_W-1:0]  host_status,
    input  logic              ctl_rd_en,
    output logic [DATA_W-1:0] ctl_rd_data,
    input  logic              ctl_spare_wr_en,
    input  logic [SPR_W-1:0]  ctl_spare_wr_data,
    input  logic              irq_en,
    output logic              irq,
    output logic              dbg_trigger
);

    logic              seq_rd;
    logic              ready_set;
    logic              ready_clr;
    logic              ibf;
    logic [DATA_W-1:0] idr;

    kcs_regs #(.DATA_W(DATA_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr_en    (host_wr_en),
        .host_wr_cmd   (host_wr_cmd),
        .host_wr_data  (host_wr_data),
        .rd_en         (ctl_rd_en | seq_rd),
        .spare_wr_en   (ctl_spare_wr_en),
        .spare_wr_data (ctl_spare_wr_data),
        .ready_set     (ready_set),
        .ready_clr     (ready_clr),
        .idr           (idr),
        .ibf           (ibf),
        .status        (host_status)
    );

    kcs_seq #(.DATA_W(DATA_W), .DEBUG_CODE(DEBUG_CODE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ibf       (ibf),
        .idr       (idr),
        .seq_rd    (seq_rd),
        .ready_set (ready_set),
        .ready_clr (ready_clr),
        .trigger   (dbg_trigger)
    );

    assign ctl_rd_data = idr;
    assign irq         = ibf & irq_en;

    // R6
    trig_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_trigger |=> (!host_status[RDY_BIT] && !dbg_trigger));

    // R9
    overwrite_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_status[IBF_BIT] && host_wr_en) |=> host_status[IBF_BIT]);

endmodule

// File: tb/kcs_doorbell_test.sv
module kcs_doorbell_test;
    import kcs_doorbell_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_en = 1'b0;
    logic       host_wr_cmd = 1'b0;
    logic [7:0] host_wr_data = '0;
    logic [7:0] host_status;
    logic       ctl_rd_en = 1'b0;
    logic [7:0] ctl_rd_data;
    logic       ctl_spare_wr_en = 1'b0;
    logic [3:0] ctl_spare_wr_data = '0;
    logic       irq_en = 1'b0;
    logic       irq;
    logic       dbg_trigger;

    int checks = 0;
    int failures = 0;
    int trig_cnt = 0;
    bit finished = 0;

    logic       m_ibf, m_cd, m_rdy;
    logic [3:0] m_spare;
    logic [7:0] m_byte;

    always #5 clk = ~clk;

    kcs_doorbell uut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_cmd(host_wr_cmd), .host_wr_data(host_wr_data),
        .host_status(host_status),
        .ctl_rd_en(ctl_rd_en), .ctl_rd_data(ctl_rd_data),
        .ctl_spare_wr_en(ctl_spare_wr_en), .ctl_spare_wr_data(ctl_spare_wr_data),
        .irq_en(irq_en), .irq(irq), .dbg_trigger(dbg_trigger)
    );

    always @(negedge clk) if (dbg_trigger) trig_cnt++;

    function automatic logic [7:0] exp_status(logic ibf, logic cd, logic rdy, logic [3:0] spr);
        logic [7:0] s;
        s = 8'h00;
        s[1] = ibf;
        s[3] = cd;
        s[4] = rdy;
        s[2] = spr[0];
        s[7] = spr[3];
        s[6] = spr[2];
        s[5] = spr[1];
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic host_write(input logic cmd, input logic [7:0] b);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_cmd = cmd; host_wr_data = b;
        @(negedge clk);
        host_wr_en = 1'b0;
        m_ibf = 1'b1; m_cd = cmd; m_byte = b;
    endtask

    task automatic spare_write(input logic [3:0] v);
        @(negedge clk);
        ctl_spare_wr_en = 1'b1; ctl_spare_wr_data = v;
        @(negedge clk);
        ctl_spare_wr_en = 1'b0;
        m_spare = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1 all status bits zero in reset
        chk("R1 reset status", host_status, 8'h00);
        chk("R8 reset irq", irq, 1'b0);
        chk("R6 reset trigger", dbg_trigger, 1'b0);
        rst_n = 1'b1;
        m_ibf = 0; m_cd = 0; m_rdy = 0; m_spare = 0;
        repeat (3) @(negedge clk);
        m_rdy = 1;
        // R4 Ready set after reset
        chk("R4 ready after reset", host_status, exp_status(0, 0, 1, 0));
        trig_cnt = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0044);
        do_reset();

        // R10 spare bits land only in 7:5 and 2
        spare_write(4'b1011);
        chk("R10 spare mapping", host_status, exp_status(0, 0, 1, 4'b1011));
        chk("R1 obf clear", host_status[0], 1'b0);

        // random non-debug bytes on both ports
        for (int i = 0; i < 40; i++) begin
            logic [7:0] b;
            logic cmd;
            b = 8'($urandom);
            if (b == 8'h44) b = 8'h45;
            cmd = 1'($urandom);
            irq_en = 1'($urandom);
            if (i % 8 == 3) spare_write(4'($urandom));
            host_write(cmd, b);
            // R2 R3 flag and byte after write
            chk("R2 ibf set / R3 cd", host_status, exp_status(1, cmd, 1, m_spare));
            chk("R2 stored byte", ctl_rd_data, b);
            // R8 interrupt follows ibf and enable
            chk("R8 irq", irq, irq_en);
            repeat (5) @(negedge clk);
            m_ibf = 0;
            // R5 byte consumed, ready kept, no trigger
            chk("R5 consumed", host_status, exp_status(0, cmd, 1, m_spare));
            chk("R5 no trigger", trig_cnt, 0);
            chk("R8 irq low after consume", irq, 1'b0);
        end

        // R9 back-to-back: debug code overwritten by other byte
        irq_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_cmd = 1'b0; host_wr_data = 8'h44;
        @(negedge clk);
        host_wr_data = 8'h10;
        @(negedge clk);
        host_wr_en = 1'b0;
        chk("R9 overwrite ibf", host_status[1], 1'b1);
        chk("R9 overwrite byte", ctl_rd_data, 8'h10);
        repeat (5) @(negedge clk);
        chk("R9 overwritten code no trigger", trig_cnt, 0);
        chk("R5 ready kept", host_status[4], 1'b1);

        // R9 back-to-back: other byte overwritten by debug code
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_cmd = 1'b0; host_wr_data = 8'h21;
        @(negedge clk);
        host_wr_data = 8'h44;
        @(negedge clk);
        host_wr_en = 1'b0;
        repeat (5) @(negedge clk);
        // R6 one pulse, ready cleared
        chk("R6 trigger count", trig_cnt, 1);
        chk("R6 ready cleared", host_status[4], 1'b0);
        chk("R6 trigger idle", dbg_trigger, 1'b0);

        // halted: further debug code not consumed
        host_write(1'b1, 8'h44);
        repeat (5) @(negedge clk);
        chk("R6 halted no new trigger", trig_cnt, 1);
        chk("R6 halted ibf held", host_status, exp_status(1, 1, 0, m_spare));
        irq_en = 1'b0;
        @(negedge clk);
        chk("R8 irq masked", irq, 1'b0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R8 irq enabled", irq, 1'b1);
        // R10 spare write does not touch ready or ibf
        spare_write(4'b0101);
        chk("R10 spare only", host_status, exp_status(1, 1, 0, 4'b0101));

        // R7 controller read
        @(negedge clk);
        ctl_rd_en = 1'b1;
        chk("R7 read data", ctl_rd_data, 8'h44);
        @(negedge clk);
        ctl_rd_en = 1'b0;
        chk("R7 ibf cleared", host_status[1], 1'b0);
        chk("R8 irq after read", irq, 1'b0);

        // R6 debug code on command port after re-arm
        do_reset();
        host_write(1'b1, 8'h44);
        repeat (5) @(negedge clk);
        chk("R6 cmd port trigger", trig_cnt, 1);
        chk("R6 cmd port status", host_status, exp_status(0, 1, 0, 0));

        finish_run();
    end

endmodule